// File: doc/BRIEF.md
# Integer Execute Stage

This block is the combinational execute stage of a 32-bit load/store RISC core. In the same cycle it takes a fetched instruction word and the two source register values that the register file has already read for it. It decodes the register-register and register-immediate arithmetic, logical and shift instructions. It returns the value to write back, the index of the destination register and a write strobe. The surrounding pipeline registers its outputs and sends them to the register file write port.

The block has no internal state. Immediates are sign- or zero-extended according to the instruction. Shift amounts come either from the instruction's shift-amount field or from the low bits of the first source register value. Adds wrap silently. Any encoding the block does not recognise leaves the write strobe low, so the instruction has no architectural effect.

Top module: `int_exec_unit`

## Requirements
- R1: The major opcode is instr[31:26]. The register form has opcode 0 and splits the word into rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. Funct 32 gives rs_val + rt_val and funct 34 gives rs_val - rt_val, both wrapped to 32 bits. Every register-form result goes to rd.
- R2: Register-form funct 36, 37, 38 and 39 give rs_val AND rt_val, OR, XOR, and NOT(rs_val OR rt_val). With rt_val = 0, funct 39 returns the bitwise inverse of rs_val.
- R3: Opcodes 8 and 9 add rs_val to the immediate instr[15:0] sign-extended to 32 bits, wrap without any trap, and write to rt.
- R4: Opcodes 12, 13 and 14 combine rs_val with the immediate zero-extended to 32 bits, by AND, OR and XOR respectively, and write to rt.
- R5: Funct 0 and funct 2 shift rt_val left and right by shamt (0 to 31), filling with zeros.
- R6: Funct 4, 6 and 7 shift rt_val left-logical, right-logical and right-arithmetic by rs_val[4:0]. The upper bits of rs_val are ignored.
- R7: Funct 3 (amount taken from shamt) and funct 7 shift right arithmetically. The vacated bits copy rt_val[31], so the result is the floor of the signed quotient by a power of two.
- R8: Any other opcode, or opcode 0 with any other funct, drives wr_en_o low, result_o to 0 and dest_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being executed |
| src_a_i | input | 32 | Value of the register named by the rs field |
| src_b_i | input | 32 | Value of the register named by the rt field |
| result_o | output | 32 | Value to write back |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | High when the instruction writes a register |

## Verification
The hardest case to reach from the ports is a variable shift whose rs value has nonzero upper bits. That case shows whether only bits 4:0 set the amount, and uniform random operands hit it almost every time but seldom with a small, distinctive low field. The stimulus therefore draws the low five bits and the upper bits of rs_val separately. A directed vector uses rs_val = 0x23, which must shift by 3. Random instruction words fill the opcode and funct fields with unused codes, so that both the rejection path and the valid encodings are exercised.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int INSN_W  = 32;
    localparam int REGIDX_W = 5;
    localparam int IMM_W   = 16;

    typedef enum logic [5:0] {
        OPC_REGFORM = 6'd0,
        OPC_ADDI    = 6'd8,
        OPC_ADDIU   = 6'd9,
        OPC_ANDI    = 6'd12,
        OPC_ORI     = 6'd13,
        OPC_XORI    = 6'd14
    } opcode_e;

    typedef enum logic [5:0] {
        FN_SLL  = 6'd0,
        FN_SRL  = 6'd2,
        FN_SRA  = 6'd3,
        FN_SLLV = 6'd4,
        FN_SRLV = 6'd6,
        FN_SRAV = 6'd7,
        FN_ADD  = 6'd32,
        FN_SUB  = 6'd34,
        FN_AND  = 6'd36,
        FN_OR   = 6'd37,
        FN_XOR  = 6'd38,
        FN_NOR  = 6'd39
    } funct_e;

    typedef enum logic [3:0] {
        XOP_ADD,
        XOP_SUB,
        XOP_AND,
        XOP_OR,
        XOP_XOR,
        XOP_NOR,
        XOP_SHL,
        XOP_SHR,
        XOP_SRA
    } xop_e;

    typedef enum logic [1:0] {
        IMM_NONE,
        IMM_SIGN,
        IMM_ZERO
    } imm_mode_e;

    typedef struct packed {
        logic      valid;
        xop_e      xop;
        imm_mode_e imm_mode;
        logic      is_shift;
        logic      amt_from_reg;
        logic      dst_is_rd;
    } exec_ctl_t;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
    import int_exec_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output exec_ctl_t  ctl_o
);

    always_comb begin
        ctl_o = '{valid: 1'b0, xop: XOP_ADD, imm_mode: IMM_NONE,
                  is_shift: 1'b0, amt_from_reg: 1'b0, dst_is_rd: 1'b0};
        if (opcode_i == OPC_REGFORM) begin
            ctl_o.dst_is_rd = 1'b1;
            ctl_o.valid     = 1'b1;
            unique case (funct_i)
                FN_ADD:  ctl_o.xop = XOP_ADD;
                FN_SUB:  ctl_o.xop = XOP_SUB;
                FN_AND:  ctl_o.xop = XOP_AND;
                FN_OR:   ctl_o.xop = XOP_OR;
                FN_XOR:  ctl_o.xop = XOP_XOR;
                FN_NOR:  ctl_o.xop = XOP_NOR;
                FN_SLL: begin
                    ctl_o.xop = XOP_SHL;
                    ctl_o.is_shift = 1'b1;
                end
                FN_SRL: begin
                    ctl_o.xop = XOP_SHR;
                    ctl_o.is_shift = 1'b1;
                end
                FN_SRA: begin
                    ctl_o.xop = XOP_SRA;
                    ctl_o.is_shift = 1'b1;
                end
                FN_SLLV: begin
                    ctl_o.xop = XOP_SHL;
                    ctl_o.is_shift = 1'b1;
                    ctl_o.amt_from_reg = 1'b1;
                end
                FN_SRLV: begin
                    ctl_o.xop = XOP_SHR;
                    ctl_o.is_shift = 1'b1;
                    ctl_o.amt_from_reg = 1'b1;
                end
                FN_SRAV: begin
                    ctl_o.xop = XOP_SRA;
                    ctl_o.is_shift = 1'b1;
                    ctl_o.amt_from_reg = 1'b1;
                end
                default: ctl_o.valid = 1'b0;
            endcase
        end else begin
            ctl_o.valid = 1'b1;
            unique case (opcode_i)
                OPC_ADDI, OPC_ADDIU: begin
                    ctl_o.xop = XOP_ADD;
                    ctl_o.imm_mode = IMM_SIGN;
                end
                OPC_ANDI: begin
                    ctl_o.xop = XOP_AND;
                    ctl_o.imm_mode = IMM_ZERO;
                end
                OPC_ORI: begin
                    ctl_o.xop = XOP_OR;
                    ctl_o.imm_mode = IMM_ZERO;
                end
                OPC_XORI: begin
                    ctl_o.xop = XOP_XOR;
                    ctl_o.imm_mode = IMM_ZERO;
                end
                default: ctl_o.valid = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/int_exec_immext.sv
module int_exec_immext
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  imm_mode_e         mode_i,
    output logic [DATA_W-1:0] ext_o
);

    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        unique case (mode_i)
            IMM_SIGN: ext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
            IMM_ZERO: ext_o = {{PAD_W{1'b0}}, imm_i};
            default:  ext_o = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_logic.sv
module int_exec_logic
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  xop_e              xop_i,
    output logic [DATA_W-1:0] res_o
);

    always_comb begin
        unique case (xop_i)
            XOP_ADD: res_o = a_i + b_i;
            XOP_SUB: res_o = a_i - b_i;
            XOP_AND: res_o = a_i & b_i;
            XOP_OR:  res_o = a_i | b_i;
            XOP_XOR: res_o = a_i ^ b_i;
            XOP_NOR: res_o = ~(a_i | b_i);
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_shift.sv
module int_exec_shift
    import int_exec_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SHIFT_IMPL = 1,
    localparam int SH_W      = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [SH_W-1:0]   amt_i,
    input  xop_e              xop_i,
    output logic [DATA_W-1:0] res_o
);

    generate
        if (SHIFT_IMPL == 0) begin : g_operator
            always_comb begin
                unique case (xop_i)
                    XOP_SHL: res_o = val_i << amt_i;
                    XOP_SHR: res_o = val_i >> amt_i;
                    XOP_SRA: res_o = DATA_W'($signed(val_i) >>> amt_i);
                    default: res_o = '0;
                endcase
            end
        end else begin : g_barrel
            logic [DATA_W-1:0] in_ord;
            logic [DATA_W-1:0] staged;
            logic              fill;

            always_comb begin
                for (int k = 0; k < DATA_W; k++) begin
                    in_ord[k] = (xop_i == XOP_SHL) ? val_i[DATA_W-1-k] : val_i[k];
                end
                fill = (xop_i == XOP_SRA) ? val_i[DATA_W-1] : 1'b0;
                staged = in_ord;
                for (int s = 0; s < SH_W; s++) begin
                    if (amt_i[s]) begin
                        staged = (staged >> (1 << s))
                               | (fill ? ~({DATA_W{1'b1}} >> (1 << s)) : '0);
                    end
                end
                for (int k = 0; k < DATA_W; k++) begin
                    res_o[k] = (xop_i == XOP_SHL) ? staged[DATA_W-1-k] : staged[k];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SHIFT_IMPL = 1
) (
    input  logic [INSN_W-1:0]   instr_i,
    input  logic [DATA_W-1:0]   src_a_i,
    input  logic [DATA_W-1:0]   src_b_i,
    output logic [DATA_W-1:0]   result_o,
    output logic [REGIDX_W-1:0] dest_o,
    output logic                wr_en_o
);

    localparam int SH_W = $clog2(DATA_W);

    exec_ctl_t         ctl;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] shift_res;
    logic [SH_W-1:0]   shift_amt;
    logic              unused_rs_field;

    assign unused_rs_field = ^instr_i[25:21];

    int_exec_decode u_decode (
        .opcode_i (instr_i[31:26]),
        .funct_i  (instr_i[5:0]),
        .ctl_o    (ctl)
    );

    int_exec_immext #(.DATA_W(DATA_W)) u_immext (
        .imm_i  (instr_i[IMM_W-1:0]),
        .mode_i (ctl.imm_mode),
        .ext_o  (imm_ext)
    );

    assign opnd_b    = (ctl.imm_mode == IMM_NONE) ? src_b_i : imm_ext;
    assign shift_amt = ctl.amt_from_reg ? src_a_i[SH_W-1:0] : SH_W'(instr_i[10:6]);

    int_exec_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i   (src_a_i),
        .b_i   (opnd_b),
        .xop_i (ctl.xop),
        .res_o (logic_res)
    );

    int_exec_shift #(.DATA_W(DATA_W), .SHIFT_IMPL(SHIFT_IMPL)) u_shift (
        .val_i (src_b_i),
        .amt_i (shift_amt),
        .xop_i (ctl.xop),
        .res_o (shift_res)
    );

    always_comb begin
        if (ctl.valid) begin
            wr_en_o  = 1'b1;
            result_o = ctl.is_shift ? shift_res : logic_res;
            dest_o   = ctl.dst_is_rd ? instr_i[15:11] : instr_i[20:16];
        end else begin
            wr_en_o  = 1'b0;
            result_o = '0;
            dest_o   = '0;
        end
    end

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk (
    input logic [31:0] instr_i,
    input logic [31:0] src_a_i,
    input logic [31:0] src_b_i,
    input logic [31:0] result_o,
    input logic [4:0]  dest_o,
    input logic        wr_en_o
);

    logic [5:0] opc;
    logic [5:0] fn;
    assign opc = instr_i[31:26];
    assign fn  = instr_i[5:0];

    always_comb begin
        // R8
        idle_quiet_chk: assert (wr_en_o || (result_o == '0 && dest_o == '0));
        // R1
        regform_dest_chk: assert (!(wr_en_o && opc == 6'd0) || dest_o == instr_i[15:11]);
        // R3
        immform_dest_chk: assert (!(wr_en_o && opc != 6'd0) || dest_o == instr_i[20:16]);
        // R1
        add_inverse_chk: assert (!(wr_en_o && opc == 6'd0 && fn == 6'd32)
                                 || (result_o - src_b_i) == src_a_i);
        // R2
        nor_disjoint_chk: assert (!(wr_en_o && opc == 6'd0 && fn == 6'd39)
                                  || ((result_o & (src_a_i | src_b_i)) == '0));
        // R4
        zext_upper_chk: assert (!(wr_en_o && opc == 6'd12) || result_o[31:16] == 16'h0);
        // R5
        srl_topzero_chk: assert (!(wr_en_o && opc == 6'd0 && fn == 6'd2 && instr_i[10:6] != 5'd0)
                                 || !result_o[31]);
        // R7
        sra_sign_chk: assert (!(wr_en_o && opc == 6'd0 && (fn == 6'd3 || fn == 6'd7))
                              || result_o[31] == src_b_i[31]);
    end

endmodule

bind int_exec_unit int_exec_unit_chk u_chk (
    .instr_i  (instr_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .result_o (result_o),
    .dest_o   (dest_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic [31:0] result;
    logic [4:0]  dest;
    logic        wr_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    int_exec_unit dut_i (
        .instr_i  (instr),
        .src_a_i  (src_a),
        .src_b_i  (src_b),
        .result_o (result),
        .dest_o   (dest),
        .wr_en_o  (wr_en)
    );

    function automatic logic [37:0] golden(input logic [31:0] ins,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
        logic [5:0]  op  = ins[31:26];
        logic [5:0]  fn  = ins[5:0];
        logic [4:0]  sa  = ins[10:6];
        logic [31:0] sx  = {{16{ins[15]}}, ins[15:0]};
        logic [31:0] zx  = {16'h0, ins[15:0]};
        logic        w   = 1'b1;
        logic [4:0]  d   = ins[20:16];
        logic [31:0] r   = '0;
        if (op == 6'd0) begin
            d = ins[15:11];
            case (fn)
                6'd32: r = a + b;
                6'd34: r = a - b;
                6'd36: r = a & b;
                6'd37: r = a | b;
                6'd38: r = a ^ b;
                6'd39: r = ~(a | b);
                6'd0:  r = b << sa;
                6'd2:  r = b >> sa;
                6'd3:  r = 32'($signed(b) >>> sa);
                6'd4:  r = b << a[4:0];
                6'd6:  r = b >> a[4:0];
                6'd7:  r = 32'($signed(b) >>> a[4:0]);
                default: w = 1'b0;
            endcase
        end else begin
            case (op)
                6'd8, 6'd9: r = a + sx;
                6'd12: r = a & zx;
                6'd13: r = a | zx;
                6'd14: r = a ^ zx;
                default: w = 1'b0;
            endcase
        end
        if (!w) begin
            r = '0;
            d = '0;
        end
        return {w, d, r};
    endfunction

    function automatic string req_tag(input logic [31:0] ins);
        logic [5:0] op = ins[31:26];
        logic [5:0] fn = ins[5:0];
        if (op == 6'd0) begin
            case (fn)
                6'd32, 6'd34: return "R1";
                6'd36, 6'd37, 6'd38, 6'd39: return "R2";
                6'd0, 6'd2: return "R5";
                6'd4, 6'd6: return "R6";
                6'd3, 6'd7: return "R7";
                default: return "R8";
            endcase
        end
        case (op)
            6'd8, 6'd9: return "R3";
            6'd12, 6'd13, 6'd14: return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic run_vec(input logic [31:0] ins, input logic [31:0] a,
                           input logic [31:0] b, input string tag);
        logic [37:0] exp;
        @(posedge clk);
        instr = ins;
        src_a = a;
        src_b = b;
        exp = golden(ins, a, b);
        @(negedge clk);
        n_cmp++;
        if ({wr_en, dest, result} !== exp) begin
            n_bad++;
            $display("FAIL %s instr=%08h a=%08h b=%08h : we/dest/result actual %0b/%0d/%08h expected %0b/%0d/%08h",
                     tag, ins, a, b, wr_en, dest, result, exp[37], exp[36:32], exp[31:0]);
        end
    endtask

    function automatic logic [31:0] mk_reg(input logic [4:0] rs, input logic [4:0] rt,
                                           input logic [4:0] rd, input logic [4:0] sa,
                                           input logic [5:0] fn);
        return {6'd0, rs, rt, rd, sa, fn};
    endfunction

    function automatic logic [31:0] mk_imm(input logic [5:0] op, input logic [4:0] rs,
                                           input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    initial begin
        logic [5:0] fn_pool [12] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd38, 6'd39,
                                     6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7};
        logic [5:0] op_pool [5]  = '{6'd8, 6'd9, 6'd12, 6'd13, 6'd14};
        void'($urandom(32'h5EED_0C01));
        instr = '0;
        src_a = '0;
        src_b = '0;

        // Rest state: all-zero word is a zero shift to register 0 (R5)
        run_vec(32'h0, 32'h0, 32'h0, "R5");
        // R1: wrapped add and subtract
        run_vec(mk_reg(5'd1, 5'd5, 5'd3, 5'd0, 6'd32), 32'h7FFF_FFFF, 32'h1, "R1");
        run_vec(mk_reg(5'd19, 5'd20, 5'd10, 5'd0, 6'd34), 32'h0, 32'h1, "R1");
        // R2: nor with zero inverts
        run_vec(mk_reg(5'd9, 5'd0, 5'd8, 5'd0, 6'd39), 32'hF234_012F, 32'h0, "R2");
        run_vec(mk_reg(5'd9, 5'd10, 5'd8, 5'd0, 6'd36), 32'hF234_012F, 32'h0000_00FF, "R2");
        // R3: add immediate -12, and sign wrap
        run_vec(32'h2268_FFF4, 32'd100, 32'hDEAD_BEEF, "R3");
        run_vec(mk_imm(6'd9, 5'd2, 5'd31, 16'h8000), 32'h0000_7FFF, 32'h0, "R3");
        // R4: zero-extended logical immediates
        run_vec(mk_imm(6'd12, 5'd9, 5'd8, 16'hFF00), 32'hFFFF_FFFF, 32'h0, "R4");
        run_vec(mk_imm(6'd13, 5'd9, 5'd8, 16'hFF00), 32'h8000_0001, 32'h0, "R4");
        run_vec(mk_imm(6'd14, 5'd9, 5'd8, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, "R4");
        // R5: shift amount extremes
        run_vec(mk_reg(5'd0, 5'd17, 5'd19, 5'd31, 6'd0), 32'h0, 32'h0000_0003, "R5");
        run_vec(mk_reg(5'd0, 5'd17, 5'd19, 5'd31, 6'd2), 32'h0, 32'hC000_0000, "R5");
        // R6: only rs_val[4:0] counts
        run_vec(mk_reg(5'd18, 5'd17, 5'd21, 5'd0, 6'd4), 32'h0000_0023, 32'h0000_00CB, "R6");
        run_vec(mk_reg(5'd18, 5'd17, 5'd21, 5'd9, 6'd6), 32'hFFFF_FFE0, 32'h8000_0000, "R6");
        // R7: arithmetic right shift floors negatives
        run_vec(mk_reg(5'd0, 5'd1, 5'd2, 5'd3, 6'd3), 32'h0, 32'hC000_0000, "R7");
        run_vec(mk_reg(5'd4, 5'd1, 5'd2, 5'd0, 6'd7), 32'h0000_001F, 32'h8000_0000, "R7");
        // R8: unused opcode and unused funct
        run_vec(mk_imm(6'd35, 5'd1, 5'd2, 16'h1234), 32'h1, 32'h2, "R8");
        run_vec(mk_reg(5'd1, 5'd2, 5'd3, 5'd0, 6'd33), 32'h1, 32'h2, "R8");

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] ins;
            logic [31:0] a;
            int sel = $urandom_range(0, 9);
            if (sel < 5)
                ins = mk_reg(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
                             fn_pool[$urandom_range(0, 11)]);
            else if (sel < 8)
                ins = mk_imm(op_pool[$urandom_range(0, 4)], 5'($urandom), 5'($urandom),
                             16'($urandom));
            else
                ins = $urandom;
            a = {27'($urandom), 5'($urandom_range(0, 31))};
            run_vec(ins, a, $urandom, req_tag(ins));
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired after %0d compares, expected completion", n_cmp);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule